// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in a memory controller's column path. It produces the column address for each beat of one read or write burst, beginning at a column given with a start strobe. Each clock after the start, it emits the next address in the chosen order. Two orders are available:

- **Sequential:** the low bits count upward.
- **Interleaved:** the low bits are the start's low bits XOR the beat index.

In both orders the addresses wrap inside an aligned block whose size is the burst length, and the column bits above that block stay fixed.

Burst lengths of 1, 2, 4 and 8 end by themselves, and the final beat is flagged. A full-page length instead walks through every column of the row in sequential order and keeps going until a stop or a new start arrives. A new start may be given on any clock. It drops the remaining beats of the current burst and begins a full-length burst from the new column. One address can be issued on every clock.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves `valid_o` = 0, `last_o` = 0 and `col_o` = 0.
- R2: `blen_i` selects the burst length: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page. The codes 3'b100, 3'b101 and 3'b110 behave as length 1.
- R3: The rising edge that samples `start_i` = 1 loads `col_o` = `start_col_i` with `valid_o` = 1. After that, one new beat appears on each rising edge.
- R4: With `btype_i` = 0 (sequential), the low log2(length) bits of beat k equal (start low bits + k) modulo the length. For example, length 4 from column 1 gives 1, 2, 3, 0.
- R5: With `btype_i` = 1 (interleaved), the low bits of beat k equal the start low bits XOR k. For example, length 8 from column 2 gives 2, 3, 0, 1, 6, 7, 4, 5.
- R6: During a fixed-length burst, the column bits above the burst-length block keep the start column's value.
- R7: `last_o` is 1 exactly on the final beat of a fixed-length burst. On the edge after that beat, `valid_o` falls to 0 unless a new start is sampled.
- R8: In full-page mode, each beat is the previous column + 1 modulo 2^COL_W. The burst never ends by itself, and `last_o` stays 0.
- R9: Full page combined with `btype_i` = 1 is handled as full page in sequential order.
- R10: A start sampled during a burst discards the remaining beats. The next beat is the new start column, followed by a full-length burst under the new settings.
- R11: An edge that samples `stop_i` = 1 without `start_i` ends any burst, so `valid_o` = 0 after it. When both are 1, the start wins. A stop while idle changes no output, and `col_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length code |
| btype_i | input | 1 | Order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The assertions check the following on every cycle:
- the start column appears one edge after the strobe;
- a burst ends after its last beat or a stop;
- no beat appears without a start;
- the upper column bits stay frozen in fixed-length bursts;
- full page advances by one and never flags a last beat.

The exact order of the low bits in sequential and interleaved bursts, the decoding of the reserved length codes, the interleaved full-page fallback and the restart from a fresh column can only be shown by the bench. It does this with its behavioural reference model, which it runs through directed and random command mixes.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b111
  } blen_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } border_e;

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             btype_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             xor_o
);

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    case (code_i)
      BL_TWO:   mask_o = COL_W'(1);
      BL_FOUR:  mask_o = COL_W'(3);
      BL_EIGHT: mask_o = COL_W'(7);
      BL_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:  mask_o = '0;
    endcase
    // interleaved order is not defined across a whole page
    xor_o = (btype_i == ORD_XOR) && !full_o;
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] dec_mask_i,
  input  logic             dec_full_i,
  input  logic             dec_xor_i,
  output logic             nxt_valid_o,
  output logic             nxt_last_o,
  output logic [COL_W-1:0] nxt_idx_o,
  output logic [COL_W-1:0] nxt_base_o,
  output logic [COL_W-1:0] nxt_mask_o,
  output logic             nxt_xor_o
);

  logic             act_q, last_q, full_q, xor_q;
  logic [COL_W-1:0] idx_q, base_q, mask_q;
  logic             nxt_full;
  logic [COL_W-1:0] idx_inc;

  assign idx_inc = idx_q + COL_W'(1);

  always_comb begin
    nxt_valid_o = 1'b0;
    nxt_last_o  = 1'b0;
    nxt_idx_o   = idx_q;
    nxt_base_o  = base_q;
    nxt_mask_o  = mask_q;
    nxt_xor_o   = xor_q;
    nxt_full    = full_q;
    if (start_i) begin
      nxt_valid_o = 1'b1;
      nxt_idx_o   = '0;
      nxt_base_o  = start_col_i;
      nxt_mask_o  = dec_mask_i;
      nxt_xor_o   = dec_xor_i;
      nxt_full    = dec_full_i;
      nxt_last_o  = !dec_full_i && (dec_mask_i == '0);
    end else if (act_q && !last_q && !stop_i) begin
      nxt_valid_o = 1'b1;
      nxt_idx_o   = idx_inc;
      nxt_last_o  = !full_q && (idx_inc == mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
      full_q <= 1'b0;
      xor_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else begin
      act_q  <= nxt_valid_o;
      last_q <= nxt_last_o;
      full_q <= nxt_full;
      xor_q  <= nxt_xor_o;
      idx_q  <= nxt_idx_o;
      base_q <= nxt_base_o;
      mask_q <= nxt_mask_o;
    end
  end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] xor_val;

  assign seq_sum = base_i + idx_i;
  assign xor_val = base_i ^ idx_i;

  // bits inside the block follow the order, bits above it keep the base
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (xor_i ? xor_val[b] : seq_sum[b]) : base_i[b];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             btype_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_xor;
  logic             nxt_valid, nxt_last, nxt_xor;
  logic [COL_W-1:0] nxt_idx, nxt_base, nxt_mask, nxt_col;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .code_i  (blen_i),
    .btype_i (btype_i),
    .mask_o  (dec_mask),
    .full_o  (dec_full),
    .xor_o   (dec_xor)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .dec_mask_i  (dec_mask),
    .dec_full_i  (dec_full),
    .dec_xor_i   (dec_xor),
    .nxt_valid_o (nxt_valid),
    .nxt_last_o  (nxt_last),
    .nxt_idx_o   (nxt_idx),
    .nxt_base_o  (nxt_base),
    .nxt_mask_o  (nxt_mask),
    .nxt_xor_o   (nxt_xor)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (nxt_base),
    .idx_i  (nxt_idx),
    .mask_i (nxt_mask),
    .xor_i  (nxt_xor),
    .col_o  (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= nxt_valid;
      last_o  <= nxt_last;
      if (nxt_valid) col_o <= nxt_col;
    end
  end

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       blen_i,
  input logic             btype_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);

  logic [COL_W-1:0] cmask_q;
  logic             cfull_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmask_q <= '0;
      cfull_q <= 1'b0;
    end else if (start_i) begin
      cfull_q <= (blen_i == 3'b111);
      case (blen_i)
        3'b001:  cmask_q <= COL_W'(1);
        3'b010:  cmask_q <= COL_W'(3);
        3'b011:  cmask_q <= COL_W'(7);
        3'b111:  cmask_q <= '1;
        default: cmask_q <= '0;
      endcase
    end
  end

  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o && (col_o == $past(start_col_i)));

  p_len_one_r2: assert property (@(posedge clk) disable iff (rst)
    start_i && (blen_i == 3'b000) |=> last_o);

  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o && !last_o && !start_i && !stop_i && !cfull_q
    |=> (col_o & ~cmask_q) == $past(col_o & ~cmask_q));

  p_last_is_beat_r7: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    last_o && !start_i |=> !valid_o);

  p_page_no_last_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o && cfull_q |-> !last_o);

  p_page_step_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o && cfull_q && !start_i && !stop_i |=> valid_o && (col_o == $past(col_o) + COL_W'(1)));

  p_stop_ends_r11: assert property (@(posedge clk) disable iff (rst)
    stop_i && !start_i |=> !valid_o);

  p_idle_stays_r11: assert property (@(posedge clk) disable iff (rst)
    !valid_o && !start_i |=> !valid_o && !last_o && $stable(col_o));

  p_burst_runs_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o && !last_o && !start_i && !stop_i |=> valid_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .blen_i      (blen_i),
  .btype_i     (btype_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;

  localparam int COL_W = 8;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       blen_i = '0;
  logic             btype_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cycles   = 0;
  string cur_req  = "R3";

  // reference model state
  int m_act = 0, m_last = 0, m_col = 0, m_start = 0, m_idx = 0, m_len = 1, m_xor = 0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut_i (
    .clk (clk), .rst (rst), .start_i (start_i), .start_col_i (start_col_i),
    .blen_i (blen_i), .btype_i (btype_i), .stop_i (stop_i),
    .col_o (col_o), .valid_o (valid_o), .last_o (last_o)
  );

  function automatic int len_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic model_beat();
    if (m_len == 0) begin
      m_col  = (m_start + m_idx) % NCOL;
      m_last = 0;
    end else begin
      int lo, base;
      lo   = m_start % m_len;
      base = m_start - lo;
      m_col  = base + (m_xor != 0 ? (lo ^ m_idx) : ((lo + m_idx) % m_len));
      m_last = (m_idx == m_len - 1);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_last = 0; m_col = 0;
    end else if (start_i) begin
      m_start = int'(start_col_i);
      m_len   = len_of(int'(blen_i));
      m_xor   = (btype_i && m_len != 0) ? 1 : 0;
      m_idx   = 0;
      m_act   = 1;
      model_beat();
    end else if (stop_i || m_act == 0 || m_last != 0) begin
      m_act = 0; m_last = 0;
    end else begin
      m_idx = m_idx + 1;
      model_beat();
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "model valid", int'(valid_o), m_act);
      chk(cur_req, "model last", int'(last_o), m_last);
      chk(cur_req, "model col", int'(col_o), m_col);
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer than 50000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic pulse_start(input int c, input int code, input int typ);
    start_i = 1'b1; start_col_i = COL_W'(c); blen_i = 3'(code); btype_i = typ[0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic beat(input string req, input int c, input int lst);
    chk(req, "beat valid", int'(valid_o), 1);
    chk(req, "beat col", int'(col_o), c);
    chk(req, "beat last", int'(last_o), lst);
    @(negedge clk);
  endtask

  task automatic expect_idle(input string req);
    chk(req, "idle valid", int'(valid_o), 0);
    chk(req, "idle last", int'(last_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", int'(valid_o), 0);
    chk("R1", "reset last", int'(last_o), 0);
    chk("R1", "reset col", int'(col_o), 0);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R4";   // sequential length 4 from 0x45, R3 R6 R7
    pulse_start(8'h45, 2, 0);
    beat("R3", 8'h45, 0); beat("R4", 8'h46, 0); beat("R4 R6", 8'h47, 0); beat("R4 R7", 8'h44, 1);
    expect_idle("R7");

    cur_req = "R5";   // interleaved length 8 from 0x12
    pulse_start(8'h12, 3, 1);
    beat("R5", 8'h12, 0); beat("R5", 8'h13, 0); beat("R5", 8'h10, 0); beat("R5", 8'h11, 0);
    beat("R5 R6", 8'h16, 0); beat("R5", 8'h17, 0); beat("R5", 8'h14, 0); beat("R5 R7", 8'h15, 1);
    expect_idle("R7");

    cur_req = "R5";   // interleaved length 4 from 0x3B
    pulse_start(8'h3B, 2, 1);
    beat("R5", 8'h3B, 0); beat("R5", 8'h3A, 0); beat("R5", 8'h39, 0); beat("R5", 8'h38, 1);

    cur_req = "R2";   // length codes
    pulse_start(8'h09, 1, 0);
    beat("R2", 8'h09, 0); beat("R2 R4", 8'h08, 1);
    pulse_start(8'h33, 0, 0);
    beat("R2", 8'h33, 1);
    expect_idle("R2");
    pulse_start(8'h77, 5, 1);
    beat("R2", 8'h77, 1);
    expect_idle("R2");

    cur_req = "R8";   // full page wraps past the top column
    pulse_start(8'hFE, 7, 0);
    beat("R8", 8'hFE, 0); beat("R8", 8'hFF, 0); beat("R8", 8'h00, 0); beat("R8", 8'h01, 0);
    repeat (300) @(negedge clk);
    chk("R8", "page still running", int'(valid_o), 1);
    cur_req = "R11";
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    expect_idle("R11");
    begin
      int held;
      held = int'(col_o);
      stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
      expect_idle("R11");
      chk("R11", "idle stop keeps col", int'(col_o), held);
    end

    cur_req = "R9";   // full page with interleave falls back to sequential
    pulse_start(8'h03, 7, 1);
    beat("R9", 8'h03, 0); beat("R9", 8'h04, 0); beat("R9", 8'h05, 0); beat("R9", 8'h06, 0);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    expect_idle("R11");

    cur_req = "R10";  // restart in the middle of a burst
    pulse_start(8'h20, 3, 0);
    beat("R10", 8'h20, 0); beat("R10", 8'h21, 0); beat("R10", 8'h22, 0);
    pulse_start(8'h37, 2, 1);
    beat("R10", 8'h37, 0); beat("R10", 8'h36, 0); beat("R10", 8'h35, 0); beat("R10", 8'h34, 1);
    expect_idle("R10");

    cur_req = "R11";  // start and stop together: start wins
    stop_i = 1'b1;
    pulse_start(8'h50, 2, 0);
    stop_i = 1'b0;
    beat("R11", 8'h50, 0); beat("R11", 8'h51, 0);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    expect_idle("R11");

    cur_req = "R10";  // random command mix against the model
    for (int i = 0; i < 3000; i++) begin
      start_i     = ($urandom % 5) == 0;
      start_col_i = COL_W'($urandom);
      blen_i      = 3'($urandom);
      btype_i     = 1'($urandom);
      stop_i      = ($urandom % 12) == 0;
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;

    rst = 1'b1;
    @(negedge clk);
    chk("R1", "reset valid late", int'(valid_o), 0);
    chk("R1", "reset last late", int'(last_o), 0);
    chk("R1", "reset col late", int'(col_o), 0);
    rst = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule